// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block supervises software by counting down a 15-bit counter and calling for help when software stops refreshing it. The counter is clocked either from the system clock through a divide-by-16 prescaler or from a one-cycle pulse, synchronised to the system clock, that marks each edge of an independent ring oscillator. Software must issue a start strobe after reset before anything counts. Any refresh strobe puts the counter back to 0x7FFF.

When the counter is at zero and another count tick arrives, the block reloads the counter and keeps counting. In interrupt mode it also raises a one-cycle interrupt request. In reset mode it instead raises a reset request that stays high for a fixed number of count ticks.

Both the clock-source choice and the mode can only move one way: toward the ring oscillator and toward reset mode. A later configuration write cannot undo either choice before the next reset.

Top module: `wdog_timer`

## Requirements
- R1: While running, each count tick lowers `count_o` by one, and the counter is 15 bits wide.
- R2: A strobe on `refresh_wr_i` sets `count_o` to 0x7FFF on the next cycle and restarts the prescaler. If a count tick falls in the same cycle as a refresh, the refresh wins and no underflow is produced.
- R3: After reset, `count_o` is 0x7FFF, `irq_o` and `rst_req_o` are low, the system-clock path and interrupt mode are selected, and the counter holds until a `start_wr_i` strobe.
- R4: With the system-clock path selected, a count tick occurs once every 16 system clock cycles, counted from the start or from the last refresh.
- R5: With the ring-oscillator path selected, a count tick occurs on each cycle in which `ro_tick_i` is high, and on no other cycle.
- R6: A count tick while `count_o` is 0 (an underflow) reloads the counter to 0x7FFF, and counting continues.
- R7: In interrupt mode, an underflow drives `irq_o` high for exactly one cycle, on the cycle in which the reload shows.
- R8: In reset mode, an underflow drives `rst_req_o` high from the reload cycle onward, and `irq_o` stays low. `rst_req_o` falls on the 4th count tick after the underflow, however many system cycles pass between ticks.
- R9: On a `cfg_wr_i` strobe, `cfg_use_ro_i`=1 selects the ring-oscillator path and `cfg_rst_mode_i`=1 selects reset mode. Once set, neither selection can be cleared by a later write; only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ro_tick_i | input | 1 | One pulse per ring-oscillator edge, synchronised to clk_i |
| start_wr_i | input | 1 | Start strobe; counting is enabled from the next cycle |
| refresh_wr_i | input | 1 | Refresh strobe; reloads the counter |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_use_ro_i | input | 1 | With cfg_wr_i: 1 selects the ring-oscillator count path |
| cfg_rst_mode_i | input | 1 | With cfg_wr_i: 1 selects reset mode, 0 leaves the mode unchanged |
| irq_o | output | 1 | Watchdog interrupt request, one-cycle pulse |
| rst_req_o | output | 1 | System reset request, held for 4 count ticks |
| count_o | output | 15 | Current counter value |

## Verification
The critical collision is a refresh strobe that arrives in the same cycle as the count tick that would underflow the counter. The bench runs the counter down to zero with ring-oscillator ticks, then drives a tick and a refresh together. It expects 0x7FFF with `irq_o` low on the next cycle. It then expects 0x7FFE after one further tick alone, which shows that the counter was reloaded by the refresh and not by an underflow.

A second overlap is a configuration write that tries to return to the system-clock path while reset mode is being entered. The bench expects the counter to stay frozen with no ring-oscillator ticks, and expects the next underflow to raise a reset request rather than an interrupt.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic {
      WD_MODE_IRQ = 1'b0,
      WD_MODE_RST = 1'b1
   } wd_mode_e;

   typedef enum logic {
      WD_SRC_SYS  = 1'b0,
      WD_SRC_RING = 1'b1
   } wd_src_e;

   localparam int unsigned WD_CNT_W_DFLT    = 15;
   localparam int unsigned WD_PRE_LOG2_DFLT = 4;
   localparam int unsigned WD_HOLD_DFLT     = 4;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned PRE_LOG2 = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);

   generate
      if (PRE_LOG2 == 0) begin : g_bypass
         assign tick_o = run_i;
      end else begin : g_divide
         logic [PRE_LOG2-1:0] div_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)        div_q <= '0;
            else if (restart_i) div_q <= '0;
            else if (run_i)     div_q <= div_q + 1'b1;
         end

         assign tick_o = run_i && (&div_q) && !restart_i;
      end
   endgenerate

endmodule

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
   import wdt_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     wr_i,
   input  logic     use_ring_i,
   input  logic     rst_mode_i,
   output wd_src_e  src_o,
   output wd_mode_e mode_o
);

   wd_src_e  src_q;
   wd_mode_e mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q  <= WD_SRC_SYS;
         mode_q <= WD_MODE_IRQ;
      end else if (wr_i) begin
         if (use_ring_i) src_q  <= WD_SRC_RING;
         if (rst_mode_i) mode_q <= WD_MODE_RST;
      end
   end

   assign src_o  = src_q;
   assign mode_o = mode_q;

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
   parameter int unsigned HOLD = 4,
   localparam int unsigned HW  = $clog2(HOLD + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   input  logic tick_i,
   output logic req_o
);

   logic [HW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      left_q <= '0;
      else if (fire_i)                  left_q <= HW'(HOLD);
      else if (tick_i && left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign req_o = (left_q != '0);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W    = WD_CNT_W_DFLT,
   parameter int unsigned PRE_LOG2 = WD_PRE_LOG2_DFLT,
   parameter int unsigned RST_HOLD = WD_HOLD_DFLT
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ro_tick_i,
   input  logic             start_wr_i,
   input  logic             refresh_wr_i,
   input  logic             cfg_wr_i,
   input  logic             cfg_use_ro_i,
   input  logic             cfg_rst_mode_i,
   output logic             irq_o,
   output logic             rst_req_o,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2 || RST_HOLD < 1) begin : g_bad_param
         $error("wdog_timer: CNT_W must be >= 2 and RST_HOLD >= 1");
      end
   endgenerate

   wd_src_e          src;
   wd_mode_e         mode;
   logic             run_q;
   logic             sys_tick;
   logic             cnt_tick;
   logic             underflow;
   logic             irq_q;
   logic [CNT_W-1:0] cnt_q;

   wdt_cfg_lock u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (cfg_wr_i),
      .use_ring_i (cfg_use_ro_i),
      .rst_mode_i (cfg_rst_mode_i),
      .src_o      (src),
      .mode_o     (mode)
   );

   wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_q && src == WD_SRC_SYS),
      .restart_i (refresh_wr_i),
      .tick_o    (sys_tick)
   );

   assign cnt_tick  = run_q && ((src == WD_SRC_RING) ? ro_tick_i : sys_tick);
   assign underflow = cnt_tick && (cnt_q == '0) && !refresh_wr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         run_q <= 1'b0;
      else if (start_wr_i) run_q <= 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= CNT_TOP;
      else if (refresh_wr_i) cnt_q <= CNT_TOP;
      else if (cnt_tick)     cnt_q <= (cnt_q == '0) ? CNT_TOP : cnt_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= underflow && (mode == WD_MODE_IRQ);
   end

   wdt_rst_stretch #(.HOLD(RST_HOLD)) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (underflow && (mode == WD_MODE_RST)),
      .tick_i (cnt_tick),
      .req_o  (rst_req_o)
   );

   assign irq_o   = irq_q;
   assign count_o = cnt_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int unsigned CNT_W = 15
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             refresh,
   input logic             tick,
   input logic             run,
   input logic             sel_ring,
   input logic             mode_rst,
   input logic             irq,
   input logic             rst_req,
   input logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   p_count_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && count != '0 && !refresh) |=> (count == $past(count) - 1'b1));

   p_refresh_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      refresh |=> (count == TOP && !irq));

   p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> $stable(count));

   p_underflow_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && count == '0 && !refresh) |=> (count == TOP));

   p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |=> !irq);

   p_irq_at_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |-> (count == TOP && !$past(mode_rst)));

   p_rst_no_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req |-> !irq);

   p_ring_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_ring |=> sel_ring);

   p_mode_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_rst |=> mode_rst);

endmodule

bind wdog_timer wdt_checker u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .refresh  (refresh_wr_i),
   .tick     (cnt_tick),
   .run      (run_q),
   .sel_ring (src == wdt_pkg::WD_SRC_RING),
   .mode_rst (mode == wdt_pkg::WD_MODE_RST),
   .irq      (irq_o),
   .rst_req  (rst_req_o),
   .count    (count_o)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ro_tick = 1'b0, start_wr = 1'b0, refresh_wr = 1'b0;
   logic        cfg_wr = 1'b0, cfg_ro = 1'b0, cfg_rm = 1'b0;
   logic        irq, rst_req;
   logic [14:0] count;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   typedef struct {
      int          at;
      logic [14:0] cnt;
      logic        irq;
      logic        rst;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_timer dut (
      .clk_i(clk), .rst_ni(rst_n), .ro_tick_i(ro_tick),
      .start_wr_i(start_wr), .refresh_wr_i(refresh_wr),
      .cfg_wr_i(cfg_wr), .cfg_use_ro_i(cfg_ro), .cfg_rst_mode_i(cfg_rm),
      .irq_o(irq), .rst_req_o(rst_req), .count_o(count)
   );

   task automatic expect_at(int at, logic [14:0] c, logic i, logic r, string req);
      exp_t e;
      e.at = at; e.cnt = c; e.irq = i; e.rst = r; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: pops scoreboard entries due in this cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (e.at != cyc || count !== e.cnt || irq !== e.irq || rst_req !== e.rst) begin
            failures++;
            $display("FAIL %s cyc=%0d: actual cnt=%h irq=%b rst=%b expected cnt=%h irq=%b rst=%b (due %0d)",
                     e.req, cyc, count, irq, rst_req, e.cnt, e.irq, e.rst, e.at);
         end
      end
   end

   task automatic drive1(logic ro, logic st, logic rf, logic cw, logic cu, logic cm);
      ro_tick = ro; start_wr = st; refresh_wr = rf;
      cfg_wr = cw; cfg_ro = cu; cfg_rm = cm;
      @(negedge clk);
      ro_tick = 0; start_wr = 0; refresh_wr = 0;
      cfg_wr = 0; cfg_ro = 0; cfg_rm = 0;
   endtask

   task automatic ro_run(int n);
      ro_tick = 1'b1;
      repeat (n) @(negedge clk);
      ro_tick = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual run still busy at cyc=%0d expected completion", cyc);
      finish_run();
   end

   initial begin
      int b;
      repeat (3) @(negedge clk);
      // R3: reset state, counter idle without start
      b = cyc;
      expect_at(b + 1, 15'h7FFF, 0, 0, "R3 reset value");
      expect_at(b + 40, 15'h7FFF, 0, 0, "R3 no count before start");
      rst_n = 1'b1;
      repeat (40) @(negedge clk);

      // R4/R1: start, system path divides by 16
      b = cyc;
      expect_at(b + 16, 15'h7FFF, 0, 0, "R4 no tick before 16 cycles");
      expect_at(b + 17, 15'h7FFE, 0, 0, "R1 R4 first tick");
      expect_at(b + 32, 15'h7FFE, 0, 0, "R4 stable between ticks");
      expect_at(b + 33, 15'h7FFD, 0, 0, "R1 R4 second tick");
      drive1(0, 1, 0, 0, 0, 0);
      repeat (39) @(negedge clk);

      // R2: refresh reloads and restarts the prescaler
      b = cyc;
      expect_at(b + 1, 15'h7FFF, 0, 0, "R2 refresh reload");
      expect_at(b + 16, 15'h7FFF, 0, 0, "R2 prescaler restarted");
      expect_at(b + 17, 15'h7FFE, 0, 0, "R2 R4 tick after refresh");
      drive1(0, 0, 1, 0, 0, 0);
      repeat (19) @(negedge clk);

      // R5/R9: switch to ring path; no ticks without ro pulses
      b = cyc;
      expect_at(b + 1, 15'h7FFF, 0, 0, "R9 R2 cfg with refresh");
      expect_at(b + 41, 15'h7FFF, 0, 0, "R5 system clock ignored on ring path");
      drive1(0, 0, 1, 1, 1, 0);
      repeat (40) @(negedge clk);

      // R5/R6/R7: run down to underflow in interrupt mode
      b = cyc;
      expect_at(b + 1, 15'h7FFE, 0, 0, "R5 ring tick");
      expect_at(b + 32767, 15'h0000, 0, 0, "R1 reaches zero");
      expect_at(b + 32768, 15'h7FFF, 1, 0, "R6 R7 underflow reload with irq");
      expect_at(b + 32769, 15'h7FFF, 0, 0, "R7 irq one cycle");
      ro_run(32768);
      @(negedge clk);

      // R2: refresh coincident with the underflowing tick
      b = cyc;
      expect_at(b + 32767, 15'h0000, 0, 0, "R1 zero again");
      expect_at(b + 32768, 15'h7FFF, 0, 0, "R2 refresh beats underflow");
      expect_at(b + 32769, 15'h7FFE, 0, 0, "R2 no underflow occurred");
      ro_run(32767);
      drive1(1, 0, 1, 0, 0, 0);
      drive1(1, 0, 0, 0, 0, 0);

      // R9: try to go back to system path while entering reset mode
      b = cyc;
      expect_at(b + 41, 15'h7FFE, 0, 0, "R9 ring selection sticky");
      drive1(0, 0, 0, 1, 0, 1);
      repeat (40) @(negedge clk);

      // R8: reset-mode underflow and hold over 4 ticks
      b = cyc;
      expect_at(b + 32766, 15'h0000, 0, 0, "R1 zero in reset mode");
      expect_at(b + 32767, 15'h7FFF, 0, 1, "R8 reset request, no irq");
      expect_at(b + 32787, 15'h7FFF, 0, 1, "R8 held without ticks");
      expect_at(b + 32788, 15'h7FFE, 0, 1, "R8 held after tick 1");
      expect_at(b + 32789, 15'h7FFD, 0, 1, "R8 held after tick 2");
      expect_at(b + 32790, 15'h7FFC, 0, 1, "R8 held after tick 3");
      expect_at(b + 32791, 15'h7FFB, 0, 0, "R8 released after tick 4");
      ro_run(32766);
      drive1(1, 0, 0, 0, 0, 0);
      repeat (20) @(negedge clk);
      for (int k = 0; k < 4; k++) drive1(1, 0, 0, 0, 0, 0);

      // R9: reset mode sticky against a clearing write
      b = cyc;
      expect_at(b + 1, 15'h7FFB, 0, 0, "R9 cfg write with zeros");
      expect_at(b + 32765, 15'h7FFF, 0, 1, "R9 mode sticky: reset not irq");
      drive1(0, 0, 0, 1, 0, 0);
      ro_run(32763);
      drive1(1, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);

      if (sb.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      finish_run();
   end

endmodule